// File: doc/BRIEF.md
# Scoped Synchronization Fence Controller

This controller sits beside a compute unit whose stores pass through a write-combining buffer into an L1 data cache. Software-visible release and acquire operations reach it tagged with a scope. A work-group scope is local to the compute unit. A device scope spans every compute unit that shares the L2. For each operation the controller runs only the cache actions that its scope demands, then returns a completion carrying the operation's tag.

The cost therefore depends on scope. A narrow release waits for the write buffer to drain. A wide release also pushes dirty L1 lines out. A wide acquire discards the L1 contents so that later loads fetch values written by other work-groups. A narrow acquire needs no cache action at all. The request and completion sides are valid/ready channels. A request is taken only on a cycle where `op_valid` and `op_ready` are both high. A completion stays on `rsp_valid` with a fixed tag until `rsp_ready` accepts it. The three cache actions use plain level-request / pulse-acknowledge pairs.

Top module: `fence_ctrl`

## Requirements
- R1: `op_ready` is high only while the controller holds no operation. From the accepting edge until the completion is taken, `op_ready` is low and `op_valid` has no effect.
- R2: `op_kind` bit 1 means release and bit 0 means acquire. `op_scope` 0 is work-group and 1 is device. A work-group release raises only `wb_drain_req`.
- R3: A device release raises `wb_drain_req` and then `l1_flush_req`, in that order, and never the invalidate.
- R4: A device acquire raises only `l1_inv_req`, starting on the cycle after acceptance.
- R5: A work-group acquire, and a `op_kind` of 00 at either scope, raise no cache request and present `rsp_valid` on the cycle after acceptance.
- R6: When both kind bits are set, the release actions run before the acquire actions. At device scope the order is drain, flush, invalidate. At work-group scope only the drain runs.
- R7: `l1_flush_req` rises only on the cycle after the drain acknowledge. At most one request line is high at a time, and each one stays high until its acknowledge.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_tag` hold steady.
- R9: After reset, `op_ready` is high and `rsp_valid` and all three request lines are low.
- R10: `rsp_tag` equals the `op_tag` of the operation being completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Fence request valid |
| op_ready | output | 1 | Controller can accept a request |
| op_kind | input | 2 | Bit 1 release, bit 0 acquire |
| op_scope | input | 1 | 0 work-group, 1 device |
| op_tag | input | TAG_W | Request identifier |
| rsp_valid | output | 1 | Completion valid |
| rsp_ready | input | 1 | Completion accepted |
| rsp_tag | output | TAG_W | Identifier of the completed request |
| wb_drain_req | output | 1 | Drain write buffer, held until acknowledged |
| wb_drain_ack | input | 1 | Pulse: all buffer entries written and acknowledged |
| l1_flush_req | output | 1 | Write back dirty L1 lines, held until acknowledged |
| l1_flush_ack | input | 1 | Pulse: flush finished |
| l1_inv_req | output | 1 | Invalidate L1, held until acknowledged |
| l1_inv_ack | input | 1 | Pulse: invalidate finished |

## Verification
The bench builds the controller with `TAG_W` set to 4. That is wide enough to give every operation in a run its own tag, so a stale or mixed-up completion tag shows up as a mismatch. A bench-side cache model acknowledges each request a fixed two cycles after it rises and records the order in which requests appear. This lets every scope and kind pairing be compared against its expected action sequence. Holding `rsp_ready` low while offering a second request makes the completion hold and the back-pressure visible at the ports.

// File: rtl/fence_pkg.sv
package fence_pkg;
  // stage order is behavioural: release work precedes acquire work
  localparam int STG_N     = 3;
  localparam int STG_DRAIN = 0;
  localparam int STG_FLUSH = 1;
  localparam int STG_INV   = 2;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fence_plan.sv
module fence_plan
  import fence_pkg::*;
(
  input  logic [1:0]       kind,
  input  logic             scope_dev,
  output logic [STG_N-1:0] stages
);
  logic is_rel, is_acq;
  assign is_rel = kind[1];
  assign is_acq = kind[0];

  always_comb begin
    stages            = '0;
    stages[STG_DRAIN] = is_rel;
    stages[STG_FLUSH] = is_rel & scope_dev;
    stages[STG_INV]   = is_acq & scope_dev;
  end
endmodule

// File: rtl/fence_seq.sv
module fence_seq
  import fence_pkg::*;
#(
  parameter int NSTG = STG_N,
  localparam int IW  = (NSTG > 1) ? $clog2(NSTG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NSTG-1:0] plan_in,
  input  logic [NSTG-1:0] ack,
  input  logic            done_take,
  output logic [NSTG-1:0] req,
  output logic            idle,
  output logic            done
);
  seq_state_e      st;
  logic [IW-1:0]   cur;
  logic [NSTG-1:0] pmask;
  logic            nxt_found, first_found;
  logic [IW-1:0]   nxt_idx, first_idx;

  // lowest pending stage above the current one
  always_comb begin
    nxt_found = 1'b0;
    nxt_idx   = '0;
    for (int i = NSTG - 1; i >= 0; i--) begin
      if (pmask[i] && (i > int'(cur))) begin
        nxt_found = 1'b1;
        nxt_idx   = IW'(i);
      end
    end
  end

  // lowest stage in a fresh plan
  always_comb begin
    first_found = 1'b0;
    first_idx   = '0;
    for (int i = NSTG - 1; i >= 0; i--) begin
      if (plan_in[i]) begin
        first_found = 1'b1;
        first_idx   = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= SQ_IDLE;
      cur   <= '0;
      pmask <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (start) begin
          pmask <= plan_in;
          cur   <= first_idx;
          st    <= first_found ? SQ_RUN : SQ_DONE;
        end
        SQ_RUN: if (ack[cur]) begin
          if (nxt_found) cur <= nxt_idx;
          else           st  <= SQ_DONE;
        end
        SQ_DONE: if (done_take) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NSTG; g++) begin : g_req
    assign req[g] = (st == SQ_RUN) && (int'(cur) == g);

    // R7: a request line stays up until its acknowledge
    assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req[g] && !ack[g] |=> req[g]);
  end

  assign idle = (st == SQ_IDLE);
  assign done = (st == SQ_DONE);

  // R7: never two cache actions in flight
  assert_one_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req));
endmodule

// File: rtl/fence_rsp.sv
module fence_rsp #(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TAG_W-1:0] tag_in,
  output logic [TAG_W-1:0] tag_out
);
  always_ff @(posedge clk) begin
    if (!rst_n)    tag_out <= '0;
    else if (load) tag_out <= tag_in;
  end
endmodule

// File: rtl/fence_ctrl.sv
module fence_ctrl
  import fence_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [1:0]       op_kind,
  input  logic             op_scope,
  input  logic [TAG_W-1:0] op_tag,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [TAG_W-1:0] rsp_tag,
  output logic             wb_drain_req,
  input  logic             wb_drain_ack,
  output logic             l1_flush_req,
  input  logic             l1_flush_ack,
  output logic             l1_inv_req,
  input  logic             l1_inv_ack
);
  logic [STG_N-1:0] plan, acks, reqs;
  logic             accept, idle, done;

  assign accept = op_valid && op_ready;

  fence_plan u_plan (
    .kind      (op_kind),
    .scope_dev (op_scope),
    .stages    (plan)
  );

  assign acks[STG_DRAIN] = wb_drain_ack;
  assign acks[STG_FLUSH] = l1_flush_ack;
  assign acks[STG_INV]   = l1_inv_ack;

  fence_seq #(.NSTG(STG_N)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .plan_in   (plan),
    .ack       (acks),
    .done_take (rsp_ready),
    .req       (reqs),
    .idle      (idle),
    .done      (done)
  );

  fence_rsp #(.TAG_W(TAG_W)) u_rsp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .tag_in  (op_tag),
    .tag_out (rsp_tag)
  );

  assign op_ready     = idle;
  assign rsp_valid    = done;
  assign wb_drain_req = reqs[STG_DRAIN];
  assign l1_flush_req = reqs[STG_FLUSH];
  assign l1_inv_req   = reqs[STG_INV];

  // R1: no acceptance while a cache action is pending
  assert_busy_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_drain_req || l1_flush_req || l1_inv_req) |-> !op_ready);

  // R7: flush follows a completed drain
  assert_flush_after_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l1_flush_req) |-> $past(wb_drain_req && wb_drain_ack));

  // R5: narrow acquire completes next cycle
  assert_wg_acq_fast_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_kind == 2'b01 && !op_scope |=> rsp_valid);

  // R4: wide acquire starts with invalidate
  assert_dev_acq_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_kind == 2'b01 && op_scope |=> l1_inv_req);

  // R8: completion holds under back-pressure
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_tag));
endmodule

// File: tb/fence_ctrl_test.sv
module fence_ctrl_test;
  localparam int TW  = 4;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, op_scope = 1'b0, rsp_ready = 1'b1;
  logic [1:0] op_kind = 2'b00;
  logic [TW-1:0] op_tag = '0;
  logic op_ready, rsp_valid;
  logic [TW-1:0] rsp_tag;
  logic wb_drain_req, l1_flush_req, l1_inv_req;
  logic [2:0] ackv = 3'b000;
  logic [2:0] reqv;
  logic [7:0] seq_log = 8'd0;
  int cnt [3] = '{0, 0, 0};
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fence_ctrl #(.TAG_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(op_kind), .op_scope(op_scope), .op_tag(op_tag),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag),
    .wb_drain_req(wb_drain_req), .wb_drain_ack(ackv[0]),
    .l1_flush_req(l1_flush_req), .l1_flush_ack(ackv[1]),
    .l1_inv_req(l1_inv_req), .l1_inv_ack(ackv[2])
  );

  assign reqv = {l1_inv_req, l1_flush_req, wb_drain_req};

  // cache model: ack LAT cycles after a request rises, log order (1 drain, 2 flush, 3 inv)
  always @(negedge clk) begin
    if (op_ready) seq_log = 8'd0;
    for (int i = 0; i < 3; i++) begin
      if (reqv[i]) begin
        if (cnt[i] == 0) seq_log = 8'(seq_log * 4 + i + 1);
        ackv[i] = (cnt[i] == LAT);
        cnt[i]  = cnt[i] + 1;
      end else begin
        ackv[i] = 1'b0;
        cnt[i]  = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // {kind, scope, expected action sequence}
  localparam logic [10:0] VEC [7] = '{
    {2'b10, 1'b0, 8'd1},   // R2 narrow release: drain
    {2'b10, 1'b1, 8'd6},   // R3 wide release: drain, flush
    {2'b01, 1'b1, 8'd3},   // R4 wide acquire: inv
    {2'b01, 1'b0, 8'd0},   // R5 narrow acquire: nothing
    {2'b11, 1'b1, 8'd27},  // R6 wide acq-rel: drain, flush, inv
    {2'b11, 1'b0, 8'd1},   // R6 narrow acq-rel: drain
    {2'b00, 1'b1, 8'd0}    // R5 empty kind: nothing
  };

  task automatic run_op(input logic [1:0] k, input logic s, input logic [TW-1:0] t,
                        input logic [7:0] exp_seq);
    int lat;
    bit rdy_seen;
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; op_scope = s; op_tag = t;
    @(negedge clk);
    op_valid = 1'b0;
    lat = 1;
    rdy_seen = 1'b0;
    while (!rsp_valid && lat < 100) begin
      if (op_ready) rdy_seen = 1'b1;
      @(negedge clk);
      lat++;
    end
    chk(!rdy_seen && !op_ready, "R1 ready low while busy", int'(op_ready), 0);
    chk(seq_log == exp_seq, "R2/R3/R4/R6 action order", int'(seq_log), int'(exp_seq));
    chk(rsp_tag == t, "R10 tag", int'(rsp_tag), int'(t));
    if (exp_seq == 8'd0) chk(lat == 1, "R5 one-cycle completion", lat, 1);
    @(negedge clk);
    chk(op_ready == 1'b1, "R1 ready after completion", int'(op_ready), 1);
  endtask

  initial begin
    int lat;
    logic [7:0] held_seq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9
    chk(op_ready == 1'b1, "R9 reset ready", int'(op_ready), 1);
    chk(rsp_valid == 1'b0, "R9 reset rsp_valid", int'(rsp_valid), 0);
    chk(reqv == 3'b000, "R9 reset requests", int'(reqv), 0);

    for (int v = 0; v < 7; v++)
      run_op(VEC[v][10:9], VEC[v][8], TW'(v + 3), VEC[v][7:0]);

    // R8 / R1: hold completion, offer a second op meanwhile
    rsp_ready = 1'b0;
    @(negedge clk);
    op_valid = 1'b1; op_kind = 2'b10; op_scope = 1'b1; op_tag = 4'hA;
    @(negedge clk);
    op_kind = 2'b01; op_tag = 4'h5;   // keep valid high, different op
    lat = 0;
    while (!rsp_valid && lat < 100) begin @(negedge clk); lat++; end
    held_seq = seq_log;
    repeat (4) @(negedge clk);
    chk(rsp_valid == 1'b1, "R8 rsp held", int'(rsp_valid), 1);
    chk(rsp_tag == 4'hA, "R8 tag held", int'(rsp_tag), 10);
    chk(seq_log == held_seq && reqv == 3'b000, "R1 second op ignored",
        int'(seq_log), int'(held_seq));
    op_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0 && op_ready == 1'b1, "R8 release on ready",
        int'(rsp_valid), 0);
    repeat (3) @(negedge clk);
    chk(reqv == 3'b000, "R1 no late start of ignored op", int'(reqv), 0);

    // R5 back-to-back narrow acquires
    run_op(2'b01, 1'b0, 4'hE, 8'd0);
    run_op(2'b01, 1'b0, 4'hF, 8'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule